// File: doc/BRIEF.md
# Private Interrupt Pending Latch and Request Filter

This block holds the pending state for the private interrupts of one processor: sixteen software-generated interrupts (bit positions 0 to 15 of the interrupt vector) and sixteen peripheral lines (bit positions 16 to 31). Peripheral lines are sampled synchronously. A line configured as edge-triggered latches a pending bit on each rising transition. A line configured as level-sensitive shows its live level directly on the pending output.

Software-generated requests arrive with an ID, a requested group and a non-secure flag. The block works out the configured group of the target ID from the group and group-modifier configuration, and it applies a coercion rule. When the request comes from the non-secure side and security is enabled, it also checks a two-bit access level for that ID. An accepted request sets the ID's pending bit. Every request gets back exactly one pulse, either accept or reject. Pending bits that the register bank clears arrive on a clear mask. Priority selection happens elsewhere.

Top module: `priv_irq_pend`

## Requirements
- R1: An edge-triggered peripheral line (its `cfg_edge_i` bit set) that goes from 0 to 1 sets its latched pending bit. The bit is visible on `pend_o` after the clock edge that samples the new level.
- R2: A level-sensitive peripheral line (its `cfg_edge_i` bit clear) appears on `pend_o` combinationally while it is high and sets no latch, so `pend_o` drops when the line drops.
- R3: An edge-triggered line that stays high or falls sets nothing. A latched bit stays set after its line falls.
- R4: Each cycle with `sgi_req_i` high produces, on the next cycle, exactly one of `sgi_acc_o` or `sgi_rej_o` for one cycle. Idle cycles produce neither.
- R5: The configured group of an ID depends on its group bit and its modifier bit. A group bit of 1 gives Non-secure Group 1 (code 2). A group bit of 0 with the modifier at 1 gives Secure Group 1 (code 1). Both bits at 0 give Group 0 (code 0). `sgi_grp_i` uses the same codes, and code 3 never matches a configured group.
- R6: A Secure Group 1 request (code 1) that targets a Group 0 interrupt is handled as a Group 0 request. Any other mismatch between the requested group and the configured group is rejected.
- R7: A non-secure request with security enabled reads the access field at bits [2*id+1:2*id] of `cfg_nsacc_i`. A Group 0 target needs a value of 1 or more. A Secure Group 1 target needs 2 or more. A Non-secure Group 1 target needs no check.
- R8: With `sec_dis_i` high, the modifier bit is ignored, so the group is Group 0 or Non-secure Group 1, and no access check is made.
- R9: A bit set in `clr_mask_i` clears its latched pending bit at the next edge. If a set for the same bit arrives in the same cycle, the set wins.
- R10: After reset, all latches are clear and `sgi_acc_o` and `sgi_rej_o` are low.
- R11: An accepted request sets only the pending bit of its ID. A rejected request changes no pending bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sec_dis_i | input | 1 | Security disabled |
| cfg_group_i | input | 16 | Group bit per software interrupt |
| cfg_grpmod_i | input | 16 | Group-modifier bit per software interrupt |
| cfg_nsacc_i | input | 32 | Two-bit non-secure access level per software interrupt |
| cfg_edge_i | input | 16 | Edge-trigger select per peripheral line |
| ppi_level_i | input | 16 | Peripheral interrupt lines |
| sgi_req_i | input | 1 | Software interrupt request valid |
| sgi_id_i | input | 4 | Target software interrupt ID |
| sgi_grp_i | input | 2 | Requested group code |
| sgi_ns_i | input | 1 | Request comes from the non-secure side |
| clr_mask_i | input | 32 | Pending-clear mask from register writes |
| pend_o | output | 32 | Effective pending vector |
| sgi_acc_o | output | 1 | Request accepted (one-cycle pulse) |
| sgi_rej_o | output | 1 | Request rejected (one-cycle pulse) |

## Verification
A table of sixteen requests, each aimed at its own ID, covers every pairing of configured group and requested group, including the coercion case and the reserved code. The table runs both with security enabled and disabled, and with access levels just below and at each threshold. This tells apart a broken group derivation, a broken coercion rule and a misplaced access-field index. The cumulative pending vector is checked after every request, which catches stray sets by rejected requests. Directed sequences on peripheral lines compare rising, held-high and falling lines in edge and level mode, and a clear that collides with a set shows which one wins.

// File: rtl/priv_irq_pkg.sv
package priv_irq_pkg;
  typedef enum logic [1:0] {
    GRP_G0   = 2'd0,
    GRP_S1   = 2'd1,
    GRP_NS1  = 2'd2,
    GRP_RSVD = 2'd3
  } grp_e;

  function automatic grp_e cfg_group(input logic grp_bit, input logic mod_bit,
                                     input logic sec_dis);
    if (grp_bit)                 return GRP_NS1;
    else if (mod_bit && !sec_dis) return GRP_S1;
    else                         return GRP_G0;
  endfunction
endpackage

// File: rtl/sgi_accept_filter.sv
module sgi_accept_filter
  import priv_irq_pkg::*;
#(
  parameter int NUM_SGI = 16,
  localparam int ID_W   = $clog2(NUM_SGI)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 req_i,
  input  logic [ID_W-1:0]      id_i,
  input  logic [1:0]           req_grp_i,
  input  logic                 ns_i,
  input  logic                 sec_dis_i,
  input  logic [NUM_SGI-1:0]   cfg_group_i,
  input  logic [NUM_SGI-1:0]   cfg_grpmod_i,
  input  logic [2*NUM_SGI-1:0] cfg_nsacc_i,
  output logic                 accept_o,
  output logic [NUM_SGI-1:0]   set_o
);
  grp_e       tgt_grp;
  grp_e       eff_grp;
  logic [1:0] acc_lvl;
  logic       grp_ok;
  logic       ns_ok;

  always_comb begin
    tgt_grp = cfg_group(cfg_group_i[id_i], cfg_grpmod_i[id_i], sec_dis_i);
    eff_grp = grp_e'(req_grp_i);
    // secure group 1 request downgrades onto a group 0 target
    if (eff_grp == GRP_S1 && tgt_grp == GRP_G0) eff_grp = GRP_G0;
    grp_ok  = (eff_grp == tgt_grp);
    acc_lvl = cfg_nsacc_i[{id_i, 1'b0} +: 2];
    ns_ok   = 1'b1;
    if (ns_i && !sec_dis_i) begin
      unique case (tgt_grp)
        GRP_G0:  ns_ok = (acc_lvl >= 2'd1);
        GRP_S1:  ns_ok = (acc_lvl >= 2'd2);
        default: ns_ok = 1'b1;
      endcase
    end
  end

  assign accept_o = req_i && grp_ok && ns_ok;

  always_comb begin
    set_o = '0;
    if (accept_o) set_o[id_i] = 1'b1;
  end

  p_set_onehot_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(set_o));
  p_reserved_drop_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && req_grp_i == 2'd3) |-> !accept_o);
  p_ns_g0_zero_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && ns_i && !sec_dis_i && !cfg_group_i[id_i] && !cfg_grpmod_i[id_i]
     && cfg_nsacc_i[{id_i, 1'b0} +: 2] == 2'd0) |-> !accept_o);
endmodule

// File: rtl/ppi_edge_detect.sv
module ppi_edge_detect #(
  parameter int NUM_PPI = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_PPI-1:0] level_i,
  output logic [NUM_PPI-1:0] rise_o
);
  logic [NUM_PPI-1:0] prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= level_i;
  end

  assign rise_o = level_i & ~prev_q;

  p_rise_needs_change_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $stable(level_i) |=> ((rise_o & $past(level_i)) == '0));
endmodule

// File: rtl/pend_latch.sv
module pend_latch #(
  parameter int WIDTH = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] set_i,
  input  logic [WIDTH-1:0] clr_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] q_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_q <= '0;
    else         q_q <= (q_q & ~clr_i) | set_i;  // set wins
  end

  assign q_o = q_q;

  p_set_wins_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|set_i) |=> ((q_q & $past(set_i)) == $past(set_i)));
  p_clear_takes_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(clr_i & ~set_i)) |=> ((q_q & $past(clr_i & ~set_i)) == '0));
endmodule

// File: rtl/priv_irq_pend.sv
module priv_irq_pend #(
  parameter int  NUM_SGI  = 16,
  parameter int  NUM_PPI  = 16,
  localparam int ID_W     = $clog2(NUM_SGI),
  localparam int NUM_IRQ  = NUM_SGI + NUM_PPI
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 sec_dis_i,
  input  logic [NUM_SGI-1:0]   cfg_group_i,
  input  logic [NUM_SGI-1:0]   cfg_grpmod_i,
  input  logic [2*NUM_SGI-1:0] cfg_nsacc_i,
  input  logic [NUM_PPI-1:0]   cfg_edge_i,
  input  logic [NUM_PPI-1:0]   ppi_level_i,
  input  logic                 sgi_req_i,
  input  logic [ID_W-1:0]      sgi_id_i,
  input  logic [1:0]           sgi_grp_i,
  input  logic                 sgi_ns_i,
  input  logic [NUM_IRQ-1:0]   clr_mask_i,
  output logic [NUM_IRQ-1:0]   pend_o,
  output logic                 sgi_acc_o,
  output logic                 sgi_rej_o
);
  logic                 accept;
  logic [NUM_SGI-1:0]   sgi_set;
  logic [NUM_PPI-1:0]   rise;
  logic [NUM_PPI-1:0]   ppi_set;
  logic [NUM_IRQ-1:0]   latch_q;
  logic                 acc_q, rej_q;

  sgi_accept_filter #(.NUM_SGI(NUM_SGI)) u_filter (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .req_i        (sgi_req_i),
    .id_i         (sgi_id_i),
    .req_grp_i    (sgi_grp_i),
    .ns_i         (sgi_ns_i),
    .sec_dis_i    (sec_dis_i),
    .cfg_group_i  (cfg_group_i),
    .cfg_grpmod_i (cfg_grpmod_i),
    .cfg_nsacc_i  (cfg_nsacc_i),
    .accept_o     (accept),
    .set_o        (sgi_set)
  );

  ppi_edge_detect #(.NUM_PPI(NUM_PPI)) u_edge (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .level_i (ppi_level_i),
    .rise_o  (rise)
  );

  assign ppi_set = rise & cfg_edge_i;

  pend_latch #(.WIDTH(NUM_IRQ)) u_latch (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  ({ppi_set, sgi_set}),
    .clr_i  (clr_mask_i),
    .q_o    (latch_q)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q <= 1'b0;
      rej_q <= 1'b0;
    end else begin
      acc_q <= sgi_req_i && accept;
      rej_q <= sgi_req_i && !accept;
    end
  end

  assign sgi_acc_o = acc_q;
  assign sgi_rej_o = rej_q;
  // level-sensitive lines bypass the latch
  assign pend_o    = latch_q | {ppi_level_i & ~cfg_edge_i, {NUM_SGI{1'b0}}};

  p_one_result_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(sgi_acc_o && sgi_rej_o));
  p_result_follows_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sgi_req_i |=> (sgi_acc_o || sgi_rej_o));
  p_idle_quiet_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sgi_req_i |=> !(sgi_acc_o || sgi_rej_o));
  p_acc_sets_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sgi_acc_o |-> latch_q[$past(sgi_id_i)]);
  p_rise_latches_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(rise & cfg_edge_i)) |=>
      ((latch_q[NUM_IRQ-1:NUM_SGI] & $past(rise & cfg_edge_i)) == $past(rise & cfg_edge_i)));
endmodule

// File: tb/priv_irq_pend_test.sv
module priv_irq_pend_test;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 16;
  // {sec_dis, grp_bit, mod_bit, nsacc[1:0], req_grp[1:0], ns, exp_acc}
  localparam logic [8:0] VEC [NV] = '{
    9'b0_0_0_00_00_0_1, 9'b0_0_0_00_00_1_0, 9'b0_0_0_01_00_1_1, 9'b0_0_0_00_01_0_1,
    9'b0_0_0_00_10_0_0, 9'b0_0_1_00_01_0_1, 9'b0_0_1_01_01_1_0, 9'b0_0_1_10_01_1_1,
    9'b0_0_1_11_00_0_0, 9'b0_1_0_00_10_1_1, 9'b0_1_1_00_01_0_0, 9'b1_0_1_00_00_1_1,
    9'b1_0_1_00_01_0_1, 9'b1_1_0_00_10_1_1, 9'b0_0_0_10_01_1_1, 9'b0_0_0_00_11_0_0
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sec_dis = 1'b0;
  logic [15:0] cfg_group = '0, cfg_grpmod = '0, cfg_edge = '0, ppi_level = '0;
  logic [31:0] cfg_nsacc = '0, clr_mask = '0;
  logic        sgi_req = 1'b0, sgi_ns = 1'b0;
  logic [3:0]  sgi_id = '0;
  logic [1:0]  sgi_grp = '0;
  logic [31:0] pend;
  logic        sgi_acc, sgi_rej;
  int          n_chk = 0, n_fail = 0;
  logic [31:0] exp_pend = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  priv_irq_pend uut (
    .clk_i(clk), .rst_ni(rst_n), .sec_dis_i(sec_dis),
    .cfg_group_i(cfg_group), .cfg_grpmod_i(cfg_grpmod), .cfg_nsacc_i(cfg_nsacc),
    .cfg_edge_i(cfg_edge), .ppi_level_i(ppi_level),
    .sgi_req_i(sgi_req), .sgi_id_i(sgi_id), .sgi_grp_i(sgi_grp), .sgi_ns_i(sgi_ns),
    .clr_mask_i(clr_mask), .pend_o(pend), .sgi_acc_o(sgi_acc), .sgi_rej_o(sgi_rej)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_fail++; n_chk++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10 reset state
    chk("R10 pend", pend, 32'h0);
    chk("R10 acc/rej", {30'h0, sgi_acc, sgi_rej}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10 after release", {pend[31:2], sgi_acc, sgi_rej}, 32'h0);

    // table: R5 R6 R7 R8 R11 R4
    for (int i = 0; i < NV; i++) begin
      logic [8:0] v;
      v = VEC[i];
      sec_dis    = v[8];
      cfg_group  = 16'(v[7]) << i;
      cfg_grpmod = 16'(v[6]) << i;
      cfg_nsacc  = 32'(v[5:4]) << (2 * i);
      sgi_grp    = v[3:2];
      sgi_ns     = v[1];
      sgi_id     = 4'(i);
      sgi_req    = 1'b1;
      @(negedge clk);
      sgi_req = 1'b0;
      if (v[0]) exp_pend[i] = 1'b1;
      chk($sformatf("R4 R6 R7 R8 result vec %0d", i), {30'h0, sgi_acc, sgi_rej},
          {30'h0, v[0], ~v[0]});
      chk($sformatf("R11 R5 pend vec %0d", i), pend, exp_pend);
    end
    @(negedge clk);
    chk("R4 idle no pulse", {30'h0, sgi_acc, sgi_rej}, 32'h0);
    sec_dis = 1'b0; cfg_group = '0; cfg_grpmod = '0; cfg_nsacc = '0;

    // R9 clear all software bits
    clr_mask = 32'h0000_ffff;
    @(negedge clk);
    clr_mask = '0;
    exp_pend = '0;
    chk("R9 clear", pend, 32'h0);

    // R1 edge-triggered rising line
    cfg_edge = 16'h0003;
    ppi_level = 16'h0001;
    @(negedge clk);
    chk("R1 rise latches", pend, 32'h0001_0000);
    // R3 falling line keeps latch
    ppi_level = 16'h0000;
    @(negedge clk);
    chk("R3 latch held after fall", pend, 32'h0001_0000);
    // R9 clear
    clr_mask = 32'h0001_0000;
    @(negedge clk);
    clr_mask = '0;
    chk("R9 clear ppi", pend, 32'h0);
    // R3 stable high: clear while high, no re-latch
    ppi_level = 16'h0002;
    @(negedge clk);
    chk("R1 second line", pend, 32'h0002_0000);
    clr_mask = 32'h0002_0000;
    @(negedge clk);
    clr_mask = '0;
    @(negedge clk);
    chk("R3 held high no reset", pend, 32'h0);
    ppi_level = '0;

    // R2 level-sensitive line
    cfg_edge = '0;
    ppi_level = 16'h0080;
    #1;
    chk("R2 level visible", pend, 32'h0080_0000);
    @(negedge clk);
    ppi_level = '0;
    #1;
    chk("R2 level drop", pend, 32'h0);

    // R9 set wins: rising edge and clear together
    cfg_edge = 16'h0004;
    @(negedge clk);
    ppi_level = 16'h0004;
    clr_mask = 32'h0004_0000;
    @(negedge clk);
    clr_mask = '0;
    chk("R9 edge beats clear", pend, 32'h0004_0000);
    // R9 set wins for accepted software request
    sgi_id = 4'd5; sgi_grp = 2'd0; sgi_ns = 1'b0; sgi_req = 1'b1;
    clr_mask = 32'h0000_0020;
    @(negedge clk);
    sgi_req = 1'b0; clr_mask = '0;
    chk("R9 request beats clear", pend, 32'h0004_0020);
    chk("R4 accept pulse", {30'h0, sgi_acc, sgi_rej}, 32'h2);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule